// File: doc/BRIEF.md
# Signalling Voltage Switch Sequencer

This block carries out the host-side steps that move an SD card's I/O signalling between the high level (3.3 V class) and the low level (1.8 V). A caller hands it one request that names the target level. The block first decides whether the slot can carry that level at all. If it can, the block stops the card clock and writes the low-level select bit. It then asks an external supply controller for the new voltage range and waits for the rail to settle. After that it restarts the clock and holds for a short quiet time. When the new level is 1.8 V, it also patches the pad calibration words with fixed codes.

If the supply controller rejects the change, the block asks again for the high range, restarts the clock, waits the quiet time and ends the sequence with an error flag. Millisecond delays come from a prescaler that runs on the block clock, so the one clock-rate parameter sets the true delays. The request port is a valid/ready pair. `req_ready` is high only while the block is idle, so a request offered during a sequence is not accepted and has no effect. The requester has to hold `req_valid` until it sees ready. The supply controller, the pads and the clock divider are outside the block.

Top module: `sig_volt_seq`

## Requirements
- R1: After reset `card_clk_en`=1, `sel_1v8`=0, `req_ready`=1, `reg_req`=0, `done`=0, and `cal_cfg`/`pad_ctrl` equal their reset parameters `CAL_RST`/`PAD_RST`.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from then until the sequence has ended. A `req_valid` offered while `req_ready` is 0 does not change the outcome, and it starts no second sequence.
- R3: When `slot_vmax_mv` is below the minimum of the target range (1800 mV for low, `req_low`=1; 2700 mV for high, `req_low`=0), the block gives `done` with `done_err`=0 within three cycles. It raises no `reg_req` and changes no output register.
- R4: `card_clk_en` goes to 0 before `sel_1v8` takes its new value, and it stays 0 for as long as `reg_req` is high.
- R5: `reg_req` stays high, with a constant range, until `reg_ack` or `reg_fail` is seen. The range is 1800/1800 mV (`reg_min_mv`/`reg_max_mv`) for low and 2700/3600 mV for high. If both arrive together, `reg_ack` wins.
- R6: After `reg_ack`, `card_clk_en` returns to 1 after 10 ms. One ms later, `done` pulses for one cycle with `done_err`=0.
- R7: After `reg_fail`, `reg_req` stays high with the 2700/3600 mV range until `reg_ack` or `reg_fail` is seen. Then `card_clk_en` returns to 1, and 1 ms later `done` pulses with `done_err`=1. `sel_1v8` keeps the value that was written, and the calibration words are not changed.
- R8: A successful low request sets `cal_cfg` bit 29 to 1, `cal_cfg[14:8]` to 0x70, `cal_cfg[6:0]` to 0x62 and `pad_ctrl[3:0]` to 0x7. All other bits of both words keep their values, and the new values are visible by the cycle of `done`.
- R9: A successful high request leaves `cal_cfg` and `pad_ctrl` unchanged.
- R10: After a sequence that is not skipped, `sel_1v8` equals `req_low` of that request.
- R11: One ms equals `CLK_KHZ` cycles of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Switch request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_low | input | 1 | Target level: 1 = 1.8 V, 0 = 3.3 V |
| slot_vmax_mv | input | 13 | Highest voltage the slot supports, in mV |
| reg_req | output | 1 | Supply change requested |
| reg_min_mv | output | 13 | Requested range minimum, in mV |
| reg_max_mv | output | 13 | Requested range maximum, in mV |
| reg_ack | input | 1 | Supply change succeeded (pulse) |
| reg_fail | input | 1 | Supply change failed (pulse) |
| card_clk_en | output | 1 | Card clock enable |
| sel_1v8 | output | 1 | Low-level signalling select bit |
| cal_cfg | output | 32 | Calibration configuration word |
| pad_ctrl | output | 32 | Pad control word |
| done | output | 1 | One-cycle end-of-sequence pulse |
| done_err | output | 1 | Sequence ended in error, valid with done |

## Verification
The hardest case to reach is the fallback path. It needs a supply failure on a low request, followed by a second exchange with a different range inside the same sequence. During that time the select bit must stay set and the calibration words must stay untouched. The bench's supply model takes, for each scenario, whether to answer the first exchange with a failure. It then checks the range shown on the held request before it acknowledges the second exchange. A request offered in the middle of the settle wait covers the ignored-request case.

// File: rtl/sig_volt_pkg.sv
package sig_volt_pkg;
  localparam int MV_W = 13;

  localparam logic [MV_W-1:0] LOW_MIN_MV  = 13'd1800;
  localparam logic [MV_W-1:0] LOW_MAX_MV  = 13'd1800;
  localparam logic [MV_W-1:0] HIGH_MIN_MV = 13'd2700;
  localparam logic [MV_W-1:0] HIGH_MAX_MV = 13'd3600;

  localparam int        CAL_EN_BIT = 29;
  localparam int        PD_LSB     = 8;
  localparam int        PU_LSB     = 0;
  localparam int        OFS_W      = 7;
  localparam logic [6:0] PD_CODE   = 7'h70;
  localparam logic [6:0] PU_CODE   = 7'h62;
  localparam int        VREF_W     = 4;
  localparam logic [3:0] VREF_CODE = 4'h7;

  localparam int MS_W      = 4;
  localparam int SETTLE_MS = 10;
  localparam int QUIET_MS  = 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GATE, ST_SETBIT, ST_REG, ST_SETTLE,
    ST_FALLBACK, ST_UNGATE, ST_QUIET, ST_CAL, ST_FINISH
  } seq_state_t;
endpackage

// File: rtl/svs_ms_timer.sv
module svs_ms_timer #(
  parameter int CLK_KHZ = 200000,
  parameter int MS_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms,
  output logic            fire
);
  localparam int PRE_W = $clog2(CLK_KHZ + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_KHZ - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  left_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      fire   <= 1'b0;
    end else if (start) begin
      pre_q  <= '0;
      left_q <= ms;
      run_q  <= 1'b1;
      fire   <= 1'b0;
    end else if (run_q) begin
      fire <= 1'b0;
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (left_q <= MS_W'(1)) begin
          run_q <= 1'b0;
          fire  <= 1'b1;
        end else begin
          left_q <= left_q - MS_W'(1);
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end else begin
      fire <= 1'b0;
    end
  end
endmodule

// File: rtl/svs_cal_patch.sv
module svs_cal_patch
  import sig_volt_pkg::*;
(
  input  logic [31:0] cal_in,
  input  logic [31:0] pad_in,
  output logic [31:0] cal_out,
  output logic [31:0] pad_out
);
  always_comb begin
    cal_out = cal_in;
    cal_out[CAL_EN_BIT] = 1'b1;
    cal_out[PD_LSB +: OFS_W] = PD_CODE;
    cal_out[PU_LSB +: OFS_W] = PU_CODE;
    pad_out = pad_in;
    pad_out[VREF_W-1:0] = VREF_CODE;
  end
endmodule

// File: rtl/sig_volt_seq.sv
module sig_volt_seq
  import sig_volt_pkg::*;
#(
  parameter int          CLK_KHZ = 200000,
  parameter logic [31:0] CAL_RST = 32'h0000_0000,
  parameter logic [31:0] PAD_RST = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_low,
  input  logic [MV_W-1:0] slot_vmax_mv,
  output logic            reg_req,
  output logic [MV_W-1:0] reg_min_mv,
  output logic [MV_W-1:0] reg_max_mv,
  input  logic            reg_ack,
  input  logic            reg_fail,
  output logic            card_clk_en,
  output logic            sel_1v8,
  output logic [31:0]     cal_cfg,
  output logic [31:0]     pad_ctrl,
  output logic            done,
  output logic            done_err
);
  seq_state_t      st_q;
  logic            tgt_low_q, fail_q;
  logic            tmr_start, tmr_fire;
  logic [MS_W-1:0] tmr_ms;
  logic [31:0]     cal_next, pad_next;
  logic            accept, skip;
  logic            want_low_range;

  assign accept = req_valid && (st_q == ST_IDLE);
  assign skip   = slot_vmax_mv < (req_low ? LOW_MIN_MV : HIGH_MIN_MV);

  svs_ms_timer #(.CLK_KHZ(CLK_KHZ), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .ms(tmr_ms), .fire(tmr_fire)
  );

  svs_cal_patch u_patch (
    .cal_in(cal_cfg), .pad_in(pad_ctrl), .cal_out(cal_next), .pad_out(pad_next)
  );

  always_comb begin
    tmr_start = 1'b0;
    tmr_ms    = MS_W'(QUIET_MS);
    if (st_q == ST_REG && reg_ack) begin
      tmr_start = 1'b1;
      tmr_ms    = MS_W'(SETTLE_MS);
    end else if (st_q == ST_UNGATE) begin
      tmr_start = 1'b1;
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign reg_req        = (st_q == ST_REG) || (st_q == ST_FALLBACK);
  assign want_low_range = (st_q == ST_REG) && tgt_low_q;
  assign reg_min_mv     = want_low_range ? LOW_MIN_MV : HIGH_MIN_MV;
  assign reg_max_mv     = want_low_range ? LOW_MAX_MV : HIGH_MAX_MV;
  assign done           = (st_q == ST_FINISH);
  assign done_err       = done && fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      tgt_low_q   <= 1'b0;
      fail_q      <= 1'b0;
      card_clk_en <= 1'b1;
      sel_1v8     <= 1'b0;
      cal_cfg     <= CAL_RST;
      pad_ctrl    <= PAD_RST;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          tgt_low_q <= req_low;
          fail_q    <= 1'b0;
          st_q      <= skip ? ST_FINISH : ST_GATE;
        end
        ST_GATE: begin
          card_clk_en <= 1'b0;
          st_q        <= ST_SETBIT;
        end
        ST_SETBIT: begin
          sel_1v8 <= tgt_low_q;
          st_q    <= ST_REG;
        end
        ST_REG: begin
          if (reg_ack) begin
            st_q <= ST_SETTLE;
          end else if (reg_fail) begin
            fail_q <= 1'b1;
            st_q   <= ST_FALLBACK;
          end
        end
        ST_SETTLE:   if (tmr_fire) st_q <= ST_UNGATE;
        ST_FALLBACK: if (reg_ack || reg_fail) st_q <= ST_UNGATE;
        ST_UNGATE: begin
          card_clk_en <= 1'b1;
          st_q        <= ST_QUIET;
        end
        ST_QUIET: if (tmr_fire) begin
          st_q <= (tgt_low_q && !fail_q) ? ST_CAL : ST_FINISH;
        end
        ST_CAL: begin
          cal_cfg  <= cal_next;
          pad_ctrl <= pad_next;
          st_q     <= ST_FINISH;
        end
        ST_FINISH: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sig_volt_seq_chk.sv
module sig_volt_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        reg_req,
  input logic [12:0] reg_min_mv,
  input logic [12:0] reg_max_mv,
  input logic        card_clk_en,
  input logic        sel_1v8,
  input logic [31:0] cal_cfg,
  input logic        done,
  input logic        done_err
);
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !req_ready);

  p_gate_before_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_1v8 != $past(sel_1v8)) |-> !card_clk_en);

  p_clk_off_in_exchange_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !card_clk_en);

  p_range_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> ((reg_min_mv == 13'd1800 && reg_max_mv == 13'd1800) ||
                 (reg_min_mv == 13'd2700 && reg_max_mv == 13'd3600)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  p_cal_on_low_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_cfg != $past(cal_cfg)) |-> (done && sel_1v8 && card_clk_en && !done_err));
endmodule

bind sig_volt_seq sig_volt_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .reg_req(reg_req),
  .reg_min_mv(reg_min_mv), .reg_max_mv(reg_max_mv), .card_clk_en(card_clk_en),
  .sel_1v8(sel_1v8), .cal_cfg(cal_cfg), .done(done), .done_err(done_err)
);

// File: tb/sig_volt_seq_tb.sv
module sig_volt_seq_tb;
  localparam int          K    = 20;
  localparam logic [31:0] CRST = 32'hA5A5_5A5A;
  localparam logic [31:0] PRST = 32'h1234_5678;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_low = 1'b0, reg_ack = 1'b0, reg_fail = 1'b0;
  logic [12:0] slot_vmax_mv = 13'd3600;
  logic req_ready, reg_req, card_clk_en, sel_1v8, done, done_err;
  logic [12:0] reg_min_mv, reg_max_mv;
  logic [31:0] cal_cfg, pad_ctrl;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] exp_cal, exp_pad;

  always #2.5 clk = ~clk;

  sig_volt_seq #(.CLK_KHZ(K), .CAL_RST(CRST), .PAD_RST(PRST)) u_dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run did not end (act %0d cycles, exp < 150000)", cyc);
      n_bad = n_bad + 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act 0x%0h exp 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // low: target level; fail: first exchange fails; busy: offer a request mid-sequence
  task automatic run_seq(input bit low, input bit fail, input bit busy);
    int t;
    logic sel0;
    sel0 = sel_1v8;
    chk(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_low = low;
    tick();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready after accept", 32'(req_ready), 0);
    t = 0;
    while (!reg_req && t < 20) begin tick(); t++; end
    chk(reg_req == 1'b1, "R5", "reg_req raised", 32'(reg_req), 1);
    chk(card_clk_en == 1'b0, "R4", "clock off in exchange", 32'(card_clk_en), 0);
    chk(sel_1v8 == low, "R10", "select bit written", 32'(sel_1v8), 32'(low));
    chk(reg_min_mv == (low ? 13'd1800 : 13'd2700), "R5", "range min",
        32'(reg_min_mv), low ? 1800 : 2700);
    chk(reg_max_mv == (low ? 13'd1800 : 13'd3600), "R5", "range max",
        32'(reg_max_mv), low ? 1800 : 3600);
    repeat (3) tick();
    chk(reg_req == 1'b1, "R5", "reg_req held without answer", 32'(reg_req), 1);
    if (fail) begin
      reg_fail = 1'b1; tick(); reg_fail = 1'b0;
      chk(reg_req == 1'b1, "R7", "fallback request held", 32'(reg_req), 1);
      chk(reg_min_mv == 13'd2700 && reg_max_mv == 13'd3600, "R7", "fallback range",
          {3'b0, reg_min_mv, 3'b0, reg_max_mv}, {16'd2700, 16'd3600});
      tick();
      reg_ack = 1'b1; tick(); reg_ack = 1'b0;
      t = 0;
      while (!card_clk_en && t < 10) begin tick(); t++; end
      chk(card_clk_en == 1'b1, "R7", "clock back after fallback", 32'(card_clk_en), 1);
    end else begin
      reg_ack = 1'b1; tick(); reg_ack = 1'b0;
      t = 1;
      while (!card_clk_en && t < 20 * K) begin
        if (busy && t == 3 * K) begin
          req_valid = 1'b1; req_low = ~low; tick(); req_valid = 1'b0; t++;
        end else begin
          tick(); t++;
        end
      end
      chk(t >= 10 * K && t <= 10 * K + 3, "R6", "settle cycles (R11 scale)", t, 10 * K);
    end
    t = 0;
    while (!done && t < 3 * K) begin tick(); t++; end
    chk(done == 1'b1, "R6", "done after quiet time", 32'(done), 1);
    chk(t >= K - 1 && t <= K + 3, "R11", "quiet cycles", t, K);
    chk(done_err == fail, "R7", "error flag", 32'(done_err), 32'(fail));
    chk(sel_1v8 == low, "R10", "select bit at end", 32'(sel_1v8), 32'(low));
    chk(cal_cfg == exp_cal, low ? "R8" : "R9", "cal_cfg", cal_cfg, exp_cal);
    chk(pad_ctrl == exp_pad, low ? "R8" : "R9", "pad_ctrl", pad_ctrl, exp_pad);
    tick();
    chk(done == 1'b0, "R6", "done single pulse", 32'(done), 0);
    if (busy) begin
      repeat (10) tick();
      chk(reg_req == 1'b0 && req_ready == 1'b1, "R2", "offered request ignored",
          {31'b0, reg_req}, 0);
      chk(sel_1v8 == low, "R2", "select unchanged by ignored request",
          32'(sel_1v8), 32'(low));
    end
    if (sel0 != low) chk(1'b1, "R4", "transition exercised", 0, 0);
  endtask

  task automatic run_skip(input bit low, input logic [12:0] vmax);
    int t;
    logic sel0, saw_req, clk_drop;
    sel0 = sel_1v8; saw_req = 1'b0; clk_drop = 1'b0;
    slot_vmax_mv = vmax;
    req_valid = 1'b1; req_low = low;
    tick();
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 3) begin
      saw_req |= reg_req; clk_drop |= ~card_clk_en; tick(); t++;
    end
    chk(done == 1'b1 && done_err == 1'b0, "R3", "skip done without error",
        {30'b0, done, done_err}, 2);
    chk(!saw_req && !clk_drop, "R3", "no exchange or gating",
        {30'b0, saw_req, clk_drop}, 0);
    chk(sel_1v8 == sel0 && cal_cfg == exp_cal && pad_ctrl == exp_pad, "R3",
        "outputs unchanged", cal_cfg, exp_cal);
    tick();
    slot_vmax_mv = 13'd3600;
  endtask

  initial begin
    exp_cal = CRST; exp_pad = PRST;
    repeat (3) tick();
    chk(card_clk_en == 1'b1 && sel_1v8 == 1'b0 && req_ready == 1'b1 &&
        reg_req == 1'b0 && done == 1'b0, "R1", "reset controls",
        {27'b0, card_clk_en, sel_1v8, req_ready, reg_req, done}, 5'b10100);
    chk(cal_cfg == CRST && pad_ctrl == PRST, "R1", "reset words", cal_cfg, CRST);
    rst_n = 1'b1;
    tick();
    // high request with 1.8 V slot: skipped
    run_skip(1'b0, 13'd1800);
    // high request on a high-level slot: words untouched
    run_seq(1'b0, 1'b0, 1'b0);
    // low request, success: calibration patched
    exp_cal = (CRST & ~32'h0000_7F7F) | 32'h2000_0000 | 32'h0000_7000 | 32'h0000_0062;
    exp_pad = (PRST & ~32'hF) | 32'h7;
    run_seq(1'b1, 1'b0, 1'b0);
    // back to high, with a request offered mid-sequence
    run_seq(1'b0, 1'b0, 1'b1);
    // low request whose supply change fails: words unchanged from previous
    run_seq(1'b1, 1'b1, 1'b0);
    // slot limited below low minimum: skipped
    run_skip(1'b1, 13'd1500);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule